// File: doc/BRIEF.md
# I2C Byte Status and Control Register

This block is the register that a host uses to follow and steer a byte-oriented I2C engine, in master or slave role. The engine's bit shifter and address comparator sit outside. They report to this block through single-cycle event pulses: byte finished (with the sampled acknowledge bit and an address flag), start seen, stop seen, arbitration lost and misplaced start/stop. The block keeps six sticky status flags and two control flags in one 8-bit register. It returns the direction and acknowledge controls to the engine.

Every finished byte raises a level interrupt. It also raises a stall request that the engine uses to hold SCL low until the host responds. The host can read the register any number of times without side effects. The host's next write of any value releases the stall. Status flags are cleared by writing 0 to their positions, and writing 1 leaves them as they are. A start condition wipes the per-transfer flags.

Top module: `i2c_scr_reg`

## Requirements
- R1: After reset the register reads 0x00, and `irq` and `stall` are low.
- R2: A `ev_byte_done` pulse sets bit 0 (byte complete) and raises `stall` and `irq` from the next cycle on.
- R3: On `ev_byte_done`, bit 1 takes the value of `ev_nack` (0 = acknowledged, 1 = not acknowledged).
- R4: `ev_byte_done` together with `ev_is_addr` sets bit 3. Only a host write of 0 clears bit 3, and a start does not clear it.
- R5: The status bits 0, 1, 3, 5, 6 and 7 are cleared by a host write of 0 at their position and are unchanged by a write of 1. Control bits 2 (transmit, 1 = transmit) and 4 (ACK out, 1 = acknowledge) take the written value.
- R6: `ev_start` clears bits 0, 1, 2 and 6.
- R7: `ev_byte_done` clears bit 4.
- R8: `stall` stays high while the host does not write, and the first host write of any value drops it.
- R9: `ev_arb_lost` sets bit 6 and on its own does not raise `irq`.
- R10: `irq` is high exactly when bit 0 or bit 7 is set.
- R11: When a hardware event sets a bit in the same cycle as a host write of 0 to it, the bit ends up set. A byte event in the same cycle as a write leaves `stall` high.
- R12: `ev_stop` sets bit 5 and `ev_bus_err` sets bit 7, and a start never clears either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current register value |
| ev_byte_done | input | 1 | Engine finished a byte |
| ev_nack | input | 1 | Acknowledge bit sampled with the byte (1 = NACK) |
| ev_is_addr | input | 1 | Finished byte was an address |
| ev_start | input | 1 | Start condition detected |
| ev_stop | input | 1 | Stop condition detected |
| ev_arb_lost | input | 1 | Arbitration lost |
| ev_bus_err | input | 1 | Misplaced start or stop |
| ctl_tx | output | 1 | Transmit direction to engine |
| ctl_ack | output | 1 | Acknowledge-out control to engine |
| irq | output | 1 | Host interrupt |
| stall | output | 1 | Request to hold SCL low |

## Verification
A host write and a hardware event on the same flag can land in one cycle. The write path wants to clear the flag or release the stall, while the event path wants to set it. The bench provokes this by pulsing `ev_byte_done` with `wr_en` and all-zero data. It judges the result by reading bit 0 and `stall` the cycle after, and both must still be high. Two full 256-value sweeps complement this: one writes every data pattern over a fully flagged register, and one applies a start after every pattern. Each result is compared with a value the bench computes by masking.

// File: rtl/i2c_scr_pkg.sv
package i2c_scr_pkg;
  localparam int REG_W  = 8;
  localparam int B_DONE = 0;
  localparam int B_LRB  = 1;
  localparam int B_TX   = 2;
  localparam int B_ADDR = 3;
  localparam int B_ACK  = 4;
  localparam int B_STOP = 5;
  localparam int B_ARB  = 6;
  localparam int B_BERR = 7;

  localparam logic [REG_W-1:0] CTL_MASK   = (REG_W'(1) << B_TX) | (REG_W'(1) << B_ACK);
  localparam logic [REG_W-1:0] RC_MASK    = ~CTL_MASK;
  localparam logic [REG_W-1:0] START_MASK = (REG_W'(1) << B_DONE) | (REG_W'(1) << B_LRB)
                                          | (REG_W'(1) << B_TX)   | (REG_W'(1) << B_ARB);
endpackage

// File: rtl/i2c_scr_rc_bit.sv
// One sticky status flag: hardware sets or loads it, software clears with 0.
module i2c_scr_rc_bit (
  input  logic clk,
  input  logic rst,
  input  logic hw_set,
  input  logic hw_load,
  input  logic hw_val,
  input  logic hw_clr,
  input  logic sw_clr,
  output logic d,
  output logic q
);
  always_comb begin
    d = q;
    if (hw_set)               d = 1'b1;
    else if (hw_load)         d = hw_val;
    else if (hw_clr || sw_clr) d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/i2c_scr_ctl_bit.sv
// One read/write control flag; a hardware clear beats a host write.
module i2c_scr_ctl_bit (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wd,
  input  logic hw_clr,
  output logic d,
  output logic q
);
  always_comb begin
    d = q;
    if (hw_clr)  d = 1'b0;
    else if (wr) d = wd;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= d;
  end
endmodule

// File: rtl/i2c_scr_hold.sv
// Stall request and interrupt flops.
module i2c_scr_hold (
  input  logic clk,
  input  logic rst,
  input  logic byte_done,
  input  logic host_wr,
  input  logic done_nxt,
  input  logic berr_nxt,
  output logic stall,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stall <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (byte_done)    stall <= 1'b1;
      else if (host_wr) stall <= 1'b0;
      irq <= done_nxt | berr_nxt;
    end
  end
endmodule

// File: rtl/i2c_scr_reg.sv
module i2c_scr_reg
  import i2c_scr_pkg::*;
#(
  parameter int W = REG_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] rd_data,
  input  logic         ev_byte_done,
  input  logic         ev_nack,
  input  logic         ev_is_addr,
  input  logic         ev_start,
  input  logic         ev_stop,
  input  logic         ev_arb_lost,
  input  logic         ev_bus_err,
  output logic         ctl_tx,
  output logic         ctl_ack,
  output logic         irq,
  output logic         stall
);
  logic [W-1:0] set_v, load_v, val_v, hclr_v, swclr_v;
  logic [W-1:0] d_v, q_v;

  always_comb begin
    set_v          = '0;
    load_v         = '0;
    val_v          = '0;
    hclr_v         = '0;
    set_v[B_DONE]  = ev_byte_done;
    load_v[B_LRB]  = ev_byte_done;
    val_v[B_LRB]   = ev_nack;
    set_v[B_ADDR]  = ev_byte_done & ev_is_addr;
    set_v[B_STOP]  = ev_stop;
    set_v[B_ARB]   = ev_arb_lost;
    set_v[B_BERR]  = ev_bus_err;
    for (int i = 0; i < W; i++) begin
      if (START_MASK[i]) hclr_v[i] = ev_start;
    end
    hclr_v[B_ACK]  = hclr_v[B_ACK] | ev_byte_done;
    swclr_v        = {W{wr_en}} & ~wr_data;
  end

  for (genvar g = 0; g < W; g++) begin : g_bit
    if (RC_MASK[g]) begin : g_rc
      i2c_scr_rc_bit u_bit (
        .clk(clk), .rst(rst), .hw_set(set_v[g]), .hw_load(load_v[g]),
        .hw_val(val_v[g]), .hw_clr(hclr_v[g]), .sw_clr(swclr_v[g]),
        .d(d_v[g]), .q(q_v[g]));
    end else begin : g_ctl
      i2c_scr_ctl_bit u_bit (
        .clk(clk), .rst(rst), .wr(wr_en), .wd(wr_data[g]),
        .hw_clr(hclr_v[g]), .d(d_v[g]), .q(q_v[g]));
    end
  end

  i2c_scr_hold u_hold (
    .clk(clk), .rst(rst), .byte_done(ev_byte_done), .host_wr(wr_en),
    .done_nxt(d_v[B_DONE]), .berr_nxt(d_v[B_BERR]),
    .stall(stall), .irq(irq));

  assign rd_data = q_v;
  assign ctl_tx  = q_v[B_TX];
  assign ctl_ack = q_v[B_ACK];
endmodule

// File: rtl/i2c_scr_reg_chk.sv
module i2c_scr_reg_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       ev_byte_done,
  input logic       ev_start,
  input logic       ev_stop,
  input logic       ev_arb_lost,
  input logic       ev_bus_err,
  input logic       ctl_tx,
  input logic       ctl_ack,
  input logic       irq,
  input logic       stall
);
  a_r2_byte_sets: assert property (@(posedge clk) disable iff (rst)
    ev_byte_done |=> rd_data[0] && stall && irq);
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !wr_en) |=> stall);
  a_r8_write_release: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ev_byte_done) |=> !stall);
  a_r10_irq_src: assert property (@(posedge clk) disable iff (rst)
    ##1 (irq == (rd_data[0] | rd_data[7])));
  a_r6_start_clear: assert property (@(posedge clk) disable iff (rst)
    (ev_start && !ev_byte_done && !ev_arb_lost) |=> (rd_data[0] | rd_data[1] | ctl_tx | rd_data[6]) == 1'b0);
  a_r12_stop_sticky: assert property (@(posedge clk) disable iff (rst)
    (ev_start && !wr_en && !ev_stop) |=> rd_data[5] == $past(rd_data[5]));
  a_r12_berr_set: assert property (@(posedge clk) disable iff (rst)
    ev_bus_err |=> rd_data[7]);
  a_r9_arb_set: assert property (@(posedge clk) disable iff (rst)
    ev_arb_lost |=> rd_data[6]);
  a_r7_ack_clear: assert property (@(posedge clk) disable iff (rst)
    ev_byte_done |=> !ctl_ack);
  a_r5_ctl_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !ev_start && !ev_byte_done) |=> ctl_tx == $past(wr_data[2]) && ctl_ack == $past(wr_data[4]));
endmodule

bind i2c_scr_reg i2c_scr_reg_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .ev_byte_done(ev_byte_done), .ev_start(ev_start), .ev_stop(ev_stop),
  .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err), .ctl_tx(ctl_tx),
  .ctl_ack(ctl_ack), .irq(irq), .stall(stall));

// File: tb/test_i2c_scr_reg.sv
module test_i2c_scr_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] START_CLR = 8'h47;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic ev_byte_done = 0, ev_nack = 0, ev_is_addr = 0, ev_start = 0;
  logic ev_stop = 0, ev_arb_lost = 0, ev_bus_err = 0;
  logic ctl_tx, ctl_ack, irq, stall;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_scr_reg i_i2c_scr_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ev_byte_done(ev_byte_done), .ev_nack(ev_nack), .ev_is_addr(ev_is_addr),
    .ev_start(ev_start), .ev_stop(ev_stop), .ev_arb_lost(ev_arb_lost),
    .ev_bus_err(ev_bus_err), .ctl_tx(ctl_tx), .ctl_ack(ctl_ack),
    .irq(irq), .stall(stall));

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Inputs applied at a falling edge, removed at the next one; outputs
  // then reflect the intervening rising edge.
  task automatic step();
    @(negedge clk);
    wr_en = 0; ev_byte_done = 0; ev_nack = 0; ev_is_addr = 0;
    ev_start = 0; ev_stop = 0; ev_arb_lost = 0; ev_bus_err = 0;
  endtask

  task automatic host_wr(logic [7:0] v);
    wr_en = 1; wr_data = v; step();
  endtask

  task automatic fill_all();
    ev_byte_done = 1; ev_nack = 1; ev_is_addr = 1; ev_stop = 1;
    ev_arb_lost = 1; ev_bus_err = 1; step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 reg", rd_data, 8'h00);
    chk("R1 irq/stall", {irq, stall}, 8'h00);

    // R2, R3: byte with ACK sampled as 0
    ev_byte_done = 1; ev_nack = 0; step();
    chk("R2 reg", rd_data, 8'h01);
    chk("R2 stall/irq", {stall, irq}, 8'h03);
    // R8: reads (idle cycles) keep stall
    step(); step(); step();
    chk("R8 stall held", {7'b0, stall}, 8'h01);
    host_wr(8'hFF);
    chk("R8 stall released", {7'b0, stall}, 8'h00);
    chk("R5 write 1 keeps", rd_data, 8'h15);
    host_wr(8'h00);
    chk("R5 write 0 clears", rd_data, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);

    // R3 nack = 1, R7 ack cleared, R4 address
    host_wr(8'h10);
    chk("R7 ack written", {6'b0, ctl_tx, ctl_ack}, 8'h01);
    ev_byte_done = 1; ev_nack = 1; ev_is_addr = 1; step();
    chk("R3 R4 R7", rd_data, 8'h0B);
    ev_start = 1; step();
    chk("R4 addr survives start", rd_data, 8'h08);
    host_wr(8'h00);

    // R9: arbitration loss alone
    ev_arb_lost = 1; step();
    chk("R9 arb bit", rd_data, 8'h40);
    chk("R9 no irq", {7'b0, irq}, 8'h00);
    host_wr(8'h00);

    // R12: stop and bus error survive start; R10 irq from bus error
    ev_stop = 1; ev_bus_err = 1; step();
    chk("R10 irq from berr", {7'b0, irq}, 8'h01);
    ev_start = 1; step();
    chk("R12 sticky over start", rd_data, 8'hA0);
    host_wr(8'h00);

    // R11: collision of byte event and clearing write
    ev_byte_done = 1; wr_en = 1; wr_data = 8'h00; step();
    chk("R11 set wins", {6'b0, rd_data[0], stall}, 8'h03);
    host_wr(8'h00);

    // R5 sweep: every write pattern over a fully flagged register
    for (int w = 0; w < 256; w++) begin
      fill_all();
      host_wr(w[7:0]);
      chk("R5 sweep", rd_data, w[7:0]);
      chk("R10 sweep", {6'b0, irq, stall}, {6'b0, w[0] | w[7], 1'b0});
    end

    // R6 sweep: start after every pattern
    for (int w = 0; w < 256; w++) begin
      fill_all();
      host_wr(w[7:0]);
      ev_start = 1; step();
      chk("R6 sweep", rd_data, w[7:0] & ~START_CLR);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule